// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides conditional branches while they sit in the decode stage of a five-stage in-order pipeline. Fetch always guesses that a branch falls through, so the fetch address keeps moving to the next sequential word. The resolver compares the two source operands at the end of decode. For an equal-compare branch or a not-equal-compare branch, it raises a redirect with the computed target when the guess was wrong. At the same moment it asks the fetch/decode register to replace its held instruction with an all-zero word, which the pipeline treats as a no-op. A wrong guess therefore costs one slot instead of three.

Operands can still be in flight when the branch needs them. The resolver has its own forwarding muxes. They take a result from the execute/memory latch or the memory/writeback latch when an older instruction is about to write a compared register. The resolver requests a decode stall when the value cannot exist yet: the producer is still in execute, or it is a load that has not finished its memory access. With a load immediately ahead of the branch, this rule stalls the branch for two cycles. With an ALU result immediately ahead, or a load two instructions ahead, it stalls for one cycle. The PC register, the instruction latch and the execute-stage forwarding sit outside this block. The block only drives their control.

Top module: `id_branch_resolver`

## Requirements
- R1: `br_target` equals `pc_plus4` plus `imm_sext` shifted left by two, modulo 2^32. This holds for every offset, including negative ones.
- R2: `br_kind` encodes 2'b01 as branch-if-equal and 2'b10 as branch-if-not-equal. When not stalled, `br_taken` is 1 exactly when the resolved operands are equal (for 2'b01) or unequal (for 2'b10).
- R3: `ifid_flush` is 1 in exactly the cycles where `br_taken` is 1.
- R4: A compared register written by the instruction in execute/memory, where that instruction is not a load, takes `exmem_val` and causes no stall.
- R5: A compared register written by the instruction in memory/writeback takes `memwb_val` and causes no stall.
- R6: When both older latches write the compared register, the execute/memory value wins over the memory/writeback value.
- R7: A compared register written by the instruction in the decode/execute latch (ALU or load) raises `id_stall`.
- R8: A compared register written by a load in the execute/memory latch raises `id_stall`. Together with R7, this gives two stall cycles after an adjacent load.
- R9: Register index 0, and any producer whose write enable is 0, never match. The operand then comes from the register-file read value, and no stall is raised.
- R10: While `id_stall` is 1, `br_taken` and `ifid_flush` are both 0.
- R11: `br_kind` 2'b00 or 2'b11 (not a branch) gives `br_taken`, `ifid_flush` and `id_stall` all 0, whatever the hazards are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the bound property checker |
| rst_n | input | 1 | Active-low reset, disables the checker |
| br_kind | input | 2 | 00 none, 01 branch-if-equal, 10 branch-if-not-equal, 11 none |
| pc_plus4 | input | 32 | Sequential address following the decoded instruction |
| imm_sext | input | 32 | Sign-extended word offset of the branch |
| rs_idx | input | 5 | First compared register index |
| rt_idx | input | 5 | Second compared register index |
| rs_rf | input | 32 | Register-file read value for `rs_idx` |
| rt_rf | input | 32 | Register-file read value for `rt_idx` |
| idex_wen | input | 1 | Decode/execute instruction writes a register |
| idex_dst | input | 5 | Decode/execute destination index |
| exmem_wen | input | 1 | Execute/memory instruction writes a register |
| exmem_is_load | input | 1 | Execute/memory instruction is a load |
| exmem_dst | input | 5 | Execute/memory destination index |
| exmem_val | input | 32 | Execute/memory ALU result |
| memwb_wen | input | 1 | Memory/writeback instruction writes a register |
| memwb_dst | input | 5 | Memory/writeback destination index |
| memwb_val | input | 32 | Memory/writeback result (ALU or loaded data) |
| br_taken | output | 1 | Redirect fetch to `br_target` |
| br_target | output | 32 | Branch destination address |
| ifid_flush | output | 1 | Replace the fetch/decode instruction with zero |
| id_stall | output | 1 | Freeze PC and fetch/decode latch, branch waits |

## Verification
On every clock cycle, the bound properties check several rules. Stalls silence the redirect and the flush. A flush only appears for a live, unstalled branch. A non-branch never stalls or redirects. A decode/execute producer of a compared register always forces a stall. Register 0 on both sides never stalls. The target keeps the byte alignment of the sequential address. The properties cannot see which forwarded value reached the comparator, the execute/memory-over-writeback priority, or the arithmetic of the target. The bench covers these by sweeping every producer placement over a small register window, with both distinct and coinciding operand values. Its timed scenarios follow an adjacent load through its two stall cycles, and an adjacent ALU result through its single stall cycle, until each branch resolves.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_EQ   = 2'b01,
        BK_NE   = 2'b10,
        BK_RSVD = 2'b11
    } br_kind_e;

    // Word offsets are turned into byte offsets.
    localparam int BR_SHIFT = 2;

    typedef struct packed {
        logic hit_idex;
        logic hit_exmem_alu;
        logic hit_exmem_load;
        logic hit_memwb;
    } src_hits_t;

    typedef struct packed {
        logic is_branch;
        logic same;
        logic hold;
        logic redirect;
    } verdict_t;

endpackage

// File: rtl/bru_operand_fwd.sv
module bru_operand_fwd
    import bru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic [XLEN-1:0]  rf_val,
    input  logic             idex_wen,
    input  logic [REG_W-1:0] idex_dst,
    input  logic             exmem_wen,
    input  logic             exmem_is_load,
    input  logic [REG_W-1:0] exmem_dst,
    input  logic [XLEN-1:0]  exmem_val,
    input  logic             memwb_wen,
    input  logic [REG_W-1:0] memwb_dst,
    input  logic [XLEN-1:0]  memwb_val,
    output logic [XLEN-1:0]  src_val,
    output logic             src_wait
);

    localparam logic [REG_W-1:0] ZERO_REG = '0;

    src_hits_t   hits_d;
    logic        live_src;

    always_comb begin
        live_src              = (src_idx != ZERO_REG);
        hits_d                = '0;
        hits_d.hit_idex       = live_src && idex_wen && (idex_dst == src_idx);
        hits_d.hit_exmem_alu  = live_src && exmem_wen && !exmem_is_load
                                && (exmem_dst == src_idx);
        hits_d.hit_exmem_load = live_src && exmem_wen && exmem_is_load
                                && (exmem_dst == src_idx);
        hits_d.hit_memwb      = live_src && memwb_wen && (memwb_dst == src_idx);
    end

    // The youngest producer decides: a value still being made forces a wait,
    // otherwise the nearest finished result is taken.
    always_comb begin
        src_wait = hits_d.hit_idex || hits_d.hit_exmem_load;
        if (hits_d.hit_exmem_alu) begin
            src_val = exmem_val;
        end else if (hits_d.hit_memwb) begin
            src_val = memwb_val;
        end else begin
            src_val = rf_val;
        end
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN  = 32,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] byte_off_d;

    always_comb begin
        byte_off_d = offset << SHIFT;
        target     = next_pc + byte_off_d;
    end

endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
    import bru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       br_kind,
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [XLEN-1:0]  imm_sext,
    input  logic [REG_W-1:0] rs_idx,
    input  logic [REG_W-1:0] rt_idx,
    input  logic [XLEN-1:0]  rs_rf,
    input  logic [XLEN-1:0]  rt_rf,
    input  logic             idex_wen,
    input  logic [REG_W-1:0] idex_dst,
    input  logic             exmem_wen,
    input  logic             exmem_is_load,
    input  logic [REG_W-1:0] exmem_dst,
    input  logic [XLEN-1:0]  exmem_val,
    input  logic             memwb_wen,
    input  logic [REG_W-1:0] memwb_dst,
    input  logic [XLEN-1:0]  memwb_val,
    output logic             br_taken,
    output logic [XLEN-1:0]  br_target,
    output logic             ifid_flush,
    output logic             id_stall
);

    localparam int NUM_SRC = 2;

    logic [REG_W-1:0]   src_idx [NUM_SRC];
    logic [XLEN-1:0]    src_rf  [NUM_SRC];
    logic [XLEN-1:0]    src_val [NUM_SRC];
    logic [NUM_SRC-1:0] src_wait;

    assign src_idx[0] = rs_idx;
    assign src_idx[1] = rt_idx;
    assign src_rf[0]  = rs_rf;
    assign src_rf[1]  = rt_rf;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            bru_operand_fwd #(
                .XLEN  (XLEN),
                .REG_W (REG_W)
            ) u_fwd (
                .src_idx       (src_idx[g]),
                .rf_val        (src_rf[g]),
                .idex_wen      (idex_wen),
                .idex_dst      (idex_dst),
                .exmem_wen     (exmem_wen),
                .exmem_is_load (exmem_is_load),
                .exmem_dst     (exmem_dst),
                .exmem_val     (exmem_val),
                .memwb_wen     (memwb_wen),
                .memwb_dst     (memwb_dst),
                .memwb_val     (memwb_val),
                .src_val       (src_val[g]),
                .src_wait      (src_wait[g])
            );
        end
    endgenerate

    bru_target #(
        .XLEN  (XLEN),
        .SHIFT (BR_SHIFT)
    ) u_tgt (
        .next_pc (pc_plus4),
        .offset  (imm_sext),
        .target  (br_target)
    );

    verdict_t verdict_d;

    always_comb begin
        verdict_d           = '0;
        verdict_d.is_branch = (br_kind == BK_EQ) || (br_kind == BK_NE);
        verdict_d.same      = (src_val[0] == src_val[1]);
        verdict_d.hold      = verdict_d.is_branch && (|src_wait);
        verdict_d.redirect  = verdict_d.is_branch && !verdict_d.hold
                              && (((br_kind == BK_EQ) && verdict_d.same)
                               || ((br_kind == BK_NE) && !verdict_d.same));
    end

    assign br_taken   = verdict_d.redirect;
    assign ifid_flush = verdict_d.redirect;
    assign id_stall   = verdict_d.hold;

endmodule

// File: rtl/id_branch_resolver_chk.sv
module id_branch_resolver_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       br_kind,
    input logic [XLEN-1:0]  pc_plus4,
    input logic [REG_W-1:0] rs_idx,
    input logic [REG_W-1:0] rt_idx,
    input logic             idex_wen,
    input logic [REG_W-1:0] idex_dst,
    input logic             br_taken,
    input logic [XLEN-1:0]  br_target,
    input logic             ifid_flush,
    input logic             id_stall
);

    logic live_br;
    assign live_br = (br_kind == 2'b01) || (br_kind == 2'b10);

    // R10: a stalled branch neither redirects nor flushes.
    p_quiet_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        id_stall |-> (!br_taken && !ifid_flush));

    // R11: non-branch encodings are inert.
    p_inert_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !live_br |-> (!br_taken && !id_stall && !ifid_flush));

    // R3: a flush comes only with a live, resolved branch.
    p_flush_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (live_br && !id_stall && br_taken));

    // R7: a decode/execute producer of rs forces a wait.
    p_idex_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_br && idex_wen && (idex_dst != '0) && (idex_dst == rs_idx))
        |-> id_stall);

    // R9: register 0 on both sides never waits.
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rs_idx == '0) && (rt_idx == '0)) |-> !id_stall);

    // R1: a word offset keeps the byte alignment of the sequential address.
    p_target_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        br_target[1:0] == pc_plus4[1:0]);

endmodule

bind id_branch_resolver id_branch_resolver_chk #(
    .XLEN  (XLEN),
    .REG_W (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_kind    (br_kind),
    .pc_plus4   (pc_plus4),
    .rs_idx     (rs_idx),
    .rt_idx     (rt_idx),
    .idex_wen   (idex_wen),
    .idex_dst   (idex_dst),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .ifid_flush (ifid_flush),
    .id_stall   (id_stall)
);

// File: tb/sim_id_branch_resolver.sv
module sim_id_branch_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  br_kind = 2'b00;
    logic [31:0] pc_plus4 = '0, imm_sext = '0;
    logic [4:0]  rs_idx = '0, rt_idx = '0;
    logic [31:0] rs_rf = '0, rt_rf = '0;
    logic        idex_wen = 1'b0;
    logic [4:0]  idex_dst = '0;
    logic        exmem_wen = 1'b0, exmem_is_load = 1'b0;
    logic [4:0]  exmem_dst = '0;
    logic [31:0] exmem_val = '0;
    logic        memwb_wen = 1'b0;
    logic [4:0]  memwb_dst = '0;
    logic [31:0] memwb_val = '0;
    logic        br_taken, ifid_flush, id_stall;
    logic [31:0] br_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    id_branch_resolver u0 (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rf_of(input int idx, input bit same_vals);
        return same_vals ? 32'h55 : 32'h1000 + 32'(idx);
    endfunction

    // Spec model for one operand: returns wait flag and resolved value.
    task automatic model_src(input int idx, input bit same_vals,
                             output bit w, output logic [31:0] v);
        w = (idx != 0) && ((idex_wen && idex_dst == 5'(idx))
             || (exmem_wen && exmem_is_load && exmem_dst == 5'(idx)));
        if (idx != 0 && exmem_wen && !exmem_is_load && exmem_dst == 5'(idx))
            v = exmem_val;
        else if (idx != 0 && memwb_wen && memwb_dst == 5'(idx))
            v = memwb_val;
        else
            v = rf_of(idx, same_vals);
    endtask

    task automatic clear_stages();
        idex_wen = 0; idex_dst = 0;
        exmem_wen = 0; exmem_is_load = 0; exmem_dst = 0; exmem_val = 0;
        memwb_wen = 0; memwb_dst = 0; memwb_val = 0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // Reset state with idle inputs.
        chk(!br_taken && !ifid_flush && !id_stall, "reset R11 outputs idle",
            {29'b0, br_taken, ifid_flush, id_stall}, 32'h0);
        chk(br_target == 32'h0, "reset R1 target", br_target, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: target arithmetic over offsets, including negative ones.
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            pc_plus4 = 32'h0040_0000 + 32'(k * 4);
            imm_sext = (k % 2 == 0) ? 32'(k * 37) : -32'(k * 53);
            if (k == 63) imm_sext = 32'hFFFF_8000;
            #1;
            chk(br_target == pc_plus4 + (imm_sext << 2), "R1 target",
                br_target, pc_plus4 + (imm_sext << 2));
        end

        // Sweep over every producer placement in a 4-register window.
        for (int vm = 0; vm < 2; vm++)
        for (int kd = 1; kd <= 2; kd++)
        for (int ie = 0; ie < 8; ie++)
        for (int em = 0; em < 16; em++)
        for (int mw = 0; mw < 8; mw++)
        for (int sr = 0; sr < 16; sr++) begin
            bit wa, wb, exp_stall, exp_taken;
            logic [31:0] va, vb;
            @(negedge clk);
            br_kind = 2'(kd);
            idex_wen = ie[2]; idex_dst = 5'(ie[1:0]);
            exmem_wen = em[3]; exmem_is_load = em[2]; exmem_dst = 5'(em[1:0]);
            memwb_wen = mw[2]; memwb_dst = 5'(mw[1:0]);
            exmem_val = vm[0] ? 32'h55 : 32'h2000;
            memwb_val = vm[0] ? 32'h55 : 32'h3000;
            rs_idx = 5'(sr[1:0]); rt_idx = 5'(sr[3:2]);
            rs_rf = rf_of(sr[1:0], vm[0]); rt_rf = rf_of(sr[3:2], vm[0]);
            #1;
            model_src(sr[1:0], vm[0], wa, va);
            model_src(sr[3:2], vm[0], wb, vb);
            exp_stall = wa || wb;
            exp_taken = !exp_stall && ((kd == 1) ? (va == vb) : (va != vb));
            // R4 R5 R6 R7 R8 R9 feed the stall and operand values; R2 R10 the decision.
            chk(id_stall == exp_stall, "sweep stall R7 R8 R9",
                {31'b0, id_stall}, {31'b0, exp_stall});
            chk(br_taken == exp_taken, "sweep taken R2 R4 R5 R6 R9 R10",
                {31'b0, br_taken}, {31'b0, exp_taken});
            chk(ifid_flush == exp_taken, "sweep flush R3",
                {31'b0, ifid_flush}, {31'b0, exp_taken});
        end

        // R11: non-branch encodings with a hazard and equal operands.
        for (int kd = 0; kd < 4; kd += 3) begin
            @(negedge clk);
            clear_stages();
            br_kind = 2'(kd); rs_idx = 5'd3; rt_idx = 5'd3;
            rs_rf = 32'h7; rt_rf = 32'h7; idex_wen = 1; idex_dst = 5'd3;
            #1;
            chk(!br_taken && !id_stall && !ifid_flush, "R11 non-branch inert",
                {29'b0, br_taken, ifid_flush, id_stall}, 32'h0);
        end

        // R6: both latches write rs, bne against exmem value -> not taken.
        @(negedge clk);
        clear_stages();
        br_kind = 2'b10; rs_idx = 5'd9; rt_idx = 5'd10;
        rs_rf = 32'h1; rt_rf = 32'hAAAA;
        exmem_wen = 1; exmem_dst = 5'd9; exmem_val = 32'hAAAA;
        memwb_wen = 1; memwb_dst = 5'd9; memwb_val = 32'hBBBB;
        #1;
        chk(!br_taken && !id_stall, "R6 exmem wins over memwb",
            {31'b0, br_taken}, 32'h0);

        // R7 then R8 then R5: load immediately before a beq, two stall cycles.
        begin
            int stalls = 0;
            @(negedge clk);
            clear_stages();
            br_kind = 2'b01; rs_idx = 5'd5; rt_idx = 5'd6;
            rs_rf = 32'hDEAD; rt_rf = 32'h1234;
            idex_wen = 1; idex_dst = 5'd5;
            #1;
            chk(id_stall && !br_taken, "R7 load in decode/execute stalls",
                {31'b0, id_stall}, 32'h1);
            if (id_stall) stalls++;
            @(negedge clk);
            idex_wen = 0; idex_dst = 0;
            exmem_wen = 1; exmem_is_load = 1; exmem_dst = 5'd5; exmem_val = 32'hFFFF;
            #1;
            chk(id_stall && !ifid_flush, "R8 load in execute/memory stalls",
                {31'b0, id_stall}, 32'h1);
            if (id_stall) stalls++;
            @(negedge clk);
            exmem_wen = 0; exmem_is_load = 0; exmem_dst = 0;
            memwb_wen = 1; memwb_dst = 5'd5; memwb_val = 32'h1234;
            #1;
            chk(!id_stall && br_taken, "R5 loaded value forwarded, taken",
                {31'b0, br_taken}, 32'h1);
            chk(ifid_flush, "R3 flush on taken", {31'b0, ifid_flush}, 32'h1);
            chk(stalls == 2, "R8 adjacent load gives two stalls",
                32'(stalls), 32'd2);
        end

        // R7 then R4: ALU result immediately before a bne, one stall cycle.
        @(negedge clk);
        clear_stages();
        br_kind = 2'b10; rs_idx = 5'd0; rt_idx = 5'd12;
        rs_rf = 32'h0; rt_rf = 32'h0;
        idex_wen = 1; idex_dst = 5'd12;
        #1;
        chk(id_stall, "R7 ALU in decode/execute stalls", {31'b0, id_stall}, 32'h1);
        @(negedge clk);
        idex_wen = 0; idex_dst = 0;
        exmem_wen = 1; exmem_dst = 5'd12; exmem_val = 32'h42;
        #1;
        chk(!id_stall && br_taken, "R4 ALU value forwarded, bne taken",
            {31'b0, br_taken}, 32'h1);

        // R9: writer of register 0 and a disabled writer are ignored.
        @(negedge clk);
        clear_stages();
        br_kind = 2'b01; rs_idx = 5'd0; rt_idx = 5'd7;
        rs_rf = 32'h0; rt_rf = 32'h0;
        idex_wen = 1; idex_dst = 5'd0;
        exmem_wen = 0; exmem_dst = 5'd7; exmem_val = 32'h9;
        #1;
        chk(!id_stall && br_taken, "R9 zero and disabled producers ignored",
            {31'b0, br_taken}, 32'h1);

        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule